// File: doc/BRIEF.md
# UART Receive Error and Break Statistics

This block keeps running statistics on the receive side of a UART. Four 16-bit event counters record characters with parity errors, characters with framing errors, characters flagged as noisy, and break conditions on the line. A fifth register holds the length of the most recent break, measured in whole characters. The receiver supplies one-cycle error strobes per character. It also supplies the line level with a bit-rate sampling tick and the configured character length in bits. The line is judged only at those tick samples.

Software uses a small register port to preset and read the counters. The counters wrap silently, so software can compute differences between two reads. A break counts as one event however long it lasts. Its duration is given in character units and is truncated toward zero.

Top module: `uart_rx_stats`

## Requirements
- R1: After reset, every readable register returns zero. Register addresses are: 0 parity-error count, 1 framing-error count, 2 noise count, 3 break count, 4 last break length. Addresses 5 to 7 always read zero.
- R2: A write with `reg_wr_i` high loads `reg_wdata_i` into the counter at addresses 0 to 3. The new value can be read in the cycle after the write.
- R3: Each cycle with `par_err_i` high advances the parity-error count by exactly one.
- R4: Each cycle with `frm_err_i` high advances the framing-error count by one, and each cycle with `noise_err_i` high advances the noise count by one. Strobes on different counters in the same cycle are all counted.
- R5: All four counters wrap from 0xFFFF to 0x0000.
- R6: A break is recognised when `char_bits_i` consecutive ticks sample the line low. The break count then rises by exactly one, however long the line stays low.
- R7: If the line returns high before `char_bits_i` consecutive low ticks, the break count and the break length do not change.
- R8: The break length register is loaded when the first high tick arrives after a break. It is loaded with floor(low ticks / `char_bits_i`), so it is accurate to within one character. It holds that value until the next break ends.
- R9: The line level is ignored in cycles without `bit_tick_i`.
- R10: When a register write and a hardware increment target the same counter in the same cycle, the written value wins.
- R11: Writes to address 4 or to addresses 5 to 7 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_err_i | input | 1 | One-cycle strobe: character had a parity error |
| frm_err_i | input | 1 | One-cycle strobe: character had a framing error |
| noise_err_i | input | 1 | One-cycle strobe: character was noisy |
| rx_level_i | input | 1 | Sampled receive line level |
| bit_tick_i | input | 1 | Bit-rate sample enable for `rx_level_i` |
| char_bits_i | input | 4 | Character length in bits (start, data, parity, stop) |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the addressed register (combinational) |

## Verification
The assertions assume the following about the inputs:
- `char_bits_i` is at least 2 and is changed only while the line is idle high.
- The error strobes are single-cycle pulses tied to characters.

The stimulus keeps to these limits in every phase:
- It sweeps character lengths from 7 to 12 bits, and changes the length only after a high tick has closed any break.
- During the break sweeps it spaces the ticks with an idle cycle in which the line is driven to the opposite level.
- It drives the error strobes only with the line held high and the tick off.

// File: rtl/uart_stats_pkg.sv
package uart_stats_pkg;
    localparam int NUM_CNT = 4;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_PARITY = 3'd0,
        ADR_FRAME  = 3'd1,
        ADR_NOISE  = 3'd2,
        ADR_BREAK  = 3'd3,
        ADR_BLEN   = 3'd4
    } stat_addr_e;
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         inc_i,
    output logic [W-1:0] value_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_i) begin
            cnt_d = wdata_i;
        end else if (inc_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value_o = cnt_q;

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> value_o == $past(wdata_i)); // R10
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !wr_i && value_o != TOP) |=> value_o == $past(value_o) + 1'b1); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !wr_i && value_o == TOP) |=> value_o == '0); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !wr_i) |=> $stable(value_o)); // R2
endmodule

// File: rtl/break_meter.sv
module break_meter #(
    parameter int LEN_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_level_i,
    input  logic             bit_tick_i,
    input  logic [LEN_W-1:0] char_bits_i,
    output logic             brk_evt_o,
    output logic [CNT_W-1:0] brk_len_o
);
    localparam logic [CNT_W-1:0] CHAR_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [LEN_W-1:0] bit_pos;
        logic [CNT_W-1:0] chars;
        logic [CNT_W-1:0] len;
    } meter_s;

    meter_s st_d, st_q;
    logic   evt_d;

    always_comb begin
        st_d  = st_q;
        evt_d = 1'b0;
        if (bit_tick_i) begin
            if (!rx_level_i) begin
                if (st_q.bit_pos == char_bits_i - 1'b1) begin
                    st_d.bit_pos = '0;
                    if (st_q.chars != CHAR_MAX) st_d.chars = st_q.chars + 1'b1;
                    evt_d = (st_q.chars == '0);
                end else begin
                    st_d.bit_pos = st_q.bit_pos + 1'b1;
                end
            end else begin
                if (st_q.chars != '0) st_d.len = st_q.chars;
                st_d.bit_pos = '0;
                st_d.chars   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign brk_evt_o = evt_d;
    assign brk_len_o = st_q.len;

    AST_CHAR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        char_bits_i >= LEN_W'(2)); // R6
    AST_EVT_ON_LOW_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt_o |-> (bit_tick_i && !rx_level_i)); // R6
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt_o |=> !brk_evt_o); // R6
    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_tick_i && rx_level_i) |=> $stable(brk_len_o)); // R8
    AST_NO_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick_i |=> $stable(st_q)); // R9
endmodule

// File: rtl/stat_read_mux.sv
module stat_read_mux
    import uart_stats_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]               blen_i,
    output logic [CNT_W-1:0]               rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADR_BLEN) begin
            rdata_o = blen_i;
        end else if (int'(addr_i) < NUM_CNT) begin
            rdata_o = cnt_i[addr_i[1:0]];
        end
    end
endmodule

// File: rtl/uart_rx_stats.sv
module uart_rx_stats
    import uart_stats_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_err_i,
    input  logic              frm_err_i,
    input  logic              noise_err_i,
    input  logic              rx_level_i,
    input  logic              bit_tick_i,
    input  logic [LEN_W-1:0]  char_bits_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [CNT_W-1:0]  reg_wdata_i,
    output logic [CNT_W-1:0]  reg_rdata_o
);
    logic [NUM_CNT-1:0]            inc_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec;
    logic                          brk_evt;
    logic [CNT_W-1:0]              brk_len;

    break_meter #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_level_i  (rx_level_i),
        .bit_tick_i  (bit_tick_i),
        .char_bits_i (char_bits_i),
        .brk_evt_o   (brk_evt),
        .brk_len_o   (brk_len)
    );

    assign inc_vec = {brk_evt, noise_err_i, frm_err_i, par_err_i};

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        stat_counter #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (reg_wr_i && (reg_addr_i == ADDR_W'(g))),
            .wdata_i (reg_wdata_i),
            .inc_i   (inc_vec[g]),
            .value_o (cnt_vec[g])
        );
    end

    stat_read_mux #(.CNT_W(CNT_W)) u_rd (
        .addr_i  (reg_addr_i),
        .cnt_i   (cnt_vec),
        .blen_i  (brk_len),
        .rdata_o (reg_rdata_o)
    );

    AST_BLEN_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !(bit_tick_i && rx_level_i)) |=> $stable(brk_len)); // R11
endmodule

// File: tb/test_uart_rx_stats.sv
module test_uart_rx_stats;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        par_err_i = 1'b0, frm_err_i = 1'b0, noise_err_i = 1'b0;
    logic        rx_level_i = 1'b1, bit_tick_i = 1'b0;
    logic [3:0]  char_bits_i = 4'd10;
    logic        reg_wr_i = 1'b0;
    logic [2:0]  reg_addr_i = 3'd0;
    logic [15:0] reg_wdata_i = 16'd0;
    logic [15:0] reg_rdata_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] e_par = 0, e_frm = 0, e_noise = 0, e_brk = 0, e_len = 0;

    always #(CLK_P/2) clk = ~clk;

    uart_rx_stats i_uart_rx_stats (
        .clk(clk), .rst_n(rst_n), .par_err_i(par_err_i), .frm_err_i(frm_err_i),
        .noise_err_i(noise_err_i), .rx_level_i(rx_level_i), .bit_tick_i(bit_tick_i),
        .char_bits_i(char_bits_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
    );

    task automatic chk(input logic [2:0] a, input logic [15:0] exp, input string req);
        reg_addr_i = a;
        #1;
        n_chk++;
        if (reg_rdata_o !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, reg_rdata_o, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(3'd0, e_par, req);
        chk(3'd1, e_frm, req);
        chk(3'd2, e_noise, req);
        chk(3'd3, e_brk, req);
        chk(3'd4, e_len, req);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    // one tick at level lv, followed by an idle cycle driving the opposite level (R9)
    task automatic tick(input logic lv);
        @(negedge clk);
        rx_level_i = lv; bit_tick_i = 1'b1;
        @(negedge clk);
        bit_tick_i = 1'b0; rx_level_i = ~lv;
        @(negedge clk);
        rx_level_i = 1'b1;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, including unused addresses
        chk_all("R1");
        for (int a = 5; a < 8; a++) chk(3'(a), 16'd0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1");

        // R3 R4: all strobe patterns, several repetitions
        for (int rep = 0; rep < 3; rep++) begin
            for (int p = 0; p < 8; p++) begin
                @(negedge clk);
                par_err_i = p[0]; frm_err_i = p[1]; noise_err_i = p[2];
                if (p[0]) e_par++;
                if (p[1]) e_frm++;
                if (p[2]) e_noise++;
                @(negedge clk);
                par_err_i = 0; frm_err_i = 0; noise_err_i = 0;
                chk(3'd0, e_par, "R3");
                chk(3'd1, e_frm, "R4");
                chk(3'd2, e_noise, "R4");
            end
        end

        // R2 R5: preset each counter near the top, then wrap
        for (int a = 0; a < 4; a++) begin
            wr(3'(a), 16'hFFFE);
            chk(3'(a), 16'hFFFE, "R2");
        end
        e_par = 16'hFFFE; e_frm = 16'hFFFE; e_noise = 16'hFFFE; e_brk = 16'hFFFE;
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            par_err_i = 1; frm_err_i = 1; noise_err_i = 1;
            @(negedge clk);
            par_err_i = 0; frm_err_i = 0; noise_err_i = 0;
            e_par++; e_frm++; e_noise++;
        end
        chk(3'd0, 16'h0001, "R5");
        chk(3'd1, 16'h0001, "R5");
        chk(3'd2, 16'h0001, "R5");
        // break counter wraps via two breaks
        char_bits_i = 4'd7;
        for (int b = 0; b < 2; b++) begin
            for (int t = 0; t < 7; t++) tick(1'b0);
            tick(1'b1);
            e_brk++;
            e_len = 16'd1;
        end
        chk(3'd3, 16'h0000, "R5");
        chk(3'd4, e_len, "R8");

        // R10: write and strobe on the same counter in the same cycle
        @(negedge clk);
        reg_wr_i = 1; reg_addr_i = 3'd0; reg_wdata_i = 16'h1234; par_err_i = 1; frm_err_i = 1;
        @(negedge clk);
        reg_wr_i = 0; par_err_i = 0; frm_err_i = 0;
        e_par = 16'h1234; e_frm++;
        chk(3'd0, e_par, "R10");
        chk(3'd1, e_frm, "R4");

        // R11: writes to length and unused addresses are ignored
        for (int a = 4; a < 8; a++) wr(3'(a), 16'hBEEF);
        chk_all("R11");
        for (int a = 5; a < 8; a++) chk(3'(a), 16'd0, "R11");

        // R6 R7 R8 R9: sweep character length and low-run length
        for (int cb = 7; cb <= 12; cb++) begin
            char_bits_i = 4'(cb);
            for (int n = 1; n <= 3 * cb + 2; n++) begin
                for (int t = 0; t < n; t++) tick(1'b0);
                if (n >= cb) begin
                    chk(3'd3, e_brk + 16'd1, "R6");
                    chk(3'd4, e_len, "R8");
                end
                tick(1'b1);
                if (n >= cb) begin
                    e_brk++;
                    e_len = 16'(n / cb);
                    chk(3'd3, e_brk, "R6");
                    chk(3'd4, e_len, "R8");
                end else begin
                    chk(3'd3, e_brk, "R7");
                    chk(3'd4, e_len, "R7");
                end
            end
        end
        chk_all("R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule